// File: doc/BRIEF.md
# UART Interrupt Status, Mask and Line Routing

This block keeps the interrupt state of a serial port controller. Event strobes from the receive, transmit, receive-timeout, modem-status and error logic set bits in an 11-bit raw status vector. A mask register selects which of those bits may reach the interrupt pins. Six output lines are formed from the masked status. One combined line covers every source, and five dedicated lines cover one source group each.

Software reaches the block through a small register port with a single write strobe, an address, write data and combinational read data. Software can read the raw status, read the masked status, write the mask, and acknowledge events by writing ones to a clear register. The clear register always reads as zero. A write to the transmit data address also raises the transmit interrupt, so the block sees that address even though it holds no data.

The block has no state machine. Its state is the raw status register and the mask register. The output lines are pure logic on those two registers and add no pipeline stage.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Reading address 3 returns, in bits [10:0], the raw status ANDed with the mask. All higher read bits are zero.
- R2: Status bit map: bits [3:0] are modem status (ring, clear-to-send, carrier detect, data-set-ready), bit 4 is receive, bit 5 is transmit, bit 6 is receive timeout, and bits [10:7] are errors. Each dedicated line is high exactly when the masked status has a set bit in its group: irq_rx for bit 4, irq_tx for bit 5, irq_rt for bit 6, irq_ms for bits [3:0] and irq_err for bits [10:7].
- R3: irq_combined is high exactly when any bit of the masked status is set, so it equals the OR of the five dedicated lines.
- R4: Writing address 4 clears every raw status bit that is one in the written value and leaves all other raw bits unchanged.
- R5: Reading address 4 always returns zero.
- R6: Writes to address 2 (raw status) and to address 3 (masked status) do not change any state.
- R7: A write to address 0 (transmit data) sets raw status bit 5. Reading address 0 returns zero.
- R8: Writing address 1 loads the mask from write data bits [10:0]. Reading address 1 returns it. The masked read and all six lines reflect the new mask in the cycle after the write edge, with no further delay.
- R9: After reset, the raw status and the mask are zero and all six lines are low.
- R10: A one on evt_set[i] for one cycle sets raw bit i. If the same bit is cleared in the same cycle, the set takes effect.
- R11: Addresses 5 to 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 tx data, 1 mask, 2 raw, 3 masked, 4 clear |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Combinational read data for reg_addr |
| evt_set | input | 11 | One-cycle set strobes, one per raw status bit |
| irq_combined | output | 1 | OR of all masked status bits |
| irq_rx | output | 1 | Masked receive interrupt |
| irq_tx | output | 1 | Masked transmit interrupt |
| irq_rt | output | 1 | Masked receive-timeout interrupt |
| irq_ms | output | 1 | OR of masked modem-status bits |
| irq_err | output | 1 | OR of masked error bits |

## Verification
The bench sweeps all 2048 mask values against two raw status patterns. This catches a line routed to the wrong group, or a group that misses a bit at the edge of its range (bits 3/4, 6/7 and 10). It raises every status bit alone to find a set strobe wired to the wrong position. It writes the read-only and unmapped addresses and then confirms that the status is unchanged. A design that decoded those writes as clears or mask loads would show a changed status or changed lines. It also sets and clears one bit in the same cycle. A design where the clear wins would lose a receive event that arrives just as software acknowledges the previous one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int STAT_W  = 11;
    localparam int ADDR_W  = 3;
    localparam int N_LINES = 6;

    localparam int BIT_RX = 4;
    localparam int BIT_TX = 5;
    localparam int BIT_RT = 6;

    localparam logic [STAT_W-1:0] GRP_MS  = 11'h00F;
    localparam logic [STAT_W-1:0] GRP_RX  = 11'h010;
    localparam logic [STAT_W-1:0] GRP_TX  = 11'h020;
    localparam logic [STAT_W-1:0] GRP_RT  = 11'h040;
    localparam logic [STAT_W-1:0] GRP_ERR = 11'h780;

    typedef enum logic [ADDR_W-1:0] {
        REG_TXDATA = 3'd0,
        REG_MASK   = 3'd1,
        REG_RAW    = 3'd2,
        REG_MASKED = 3'd3,
        REG_CLEAR  = 3'd4
    } reg_sel_e;

    // Line 0 is the combined line; lines 1..5 are rx, tx, rt, modem, error.
    function automatic logic [STAT_W-1:0] line_group(input int idx);
        case (idx)
            0:       return GRP_MS | GRP_RX | GRP_TX | GRP_RT | GRP_ERR;
            1:       return GRP_RX;
            2:       return GRP_TX;
            3:       return GRP_RT;
            4:       return GRP_MS;
            default: return GRP_ERR;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_raw_reg.sv
module uart_irq_raw_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] raw
);
    logic [W-1:0] raw_d;

    // a set in the same cycle beats the clear
    always_comb raw_d = (raw & ~clr_vec) | set_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= raw_d;
    end
endmodule

// File: rtl/uart_irq_mask_reg.sv
module uart_irq_mask_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] mask
);
    always_ff @(posedge clk) begin
        if (!rst_n)    mask <= '0;
        else if (load) mask <= din;
    end
endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
    import uart_irq_pkg::*;
#(
    parameter int W = STAT_W,
    parameter int N = N_LINES
) (
    input  logic [W-1:0] masked,
    output logic [N-1:0] lines
);
    for (genvar k = 0; k < N; k++) begin : g_line
        localparam logic [W-1:0] SEL = line_group(k);
        assign lines[k] = |(masked & SEL);
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [STAT_W-1:0] evt_set,
    output logic              irq_combined,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_rt,
    output logic              irq_ms,
    output logic              irq_err
);
    localparam int PAD_W = DATA_W - STAT_W;

    logic [STAT_W-1:0]  raw_q, mask_q, masked, set_all, clr_vec;
    logic [N_LINES-1:0] lines;
    logic               wr_tx, wr_mask, wr_clr;

    always_comb begin
        wr_tx   = reg_wr && (reg_addr == REG_TXDATA);
        wr_mask = reg_wr && (reg_addr == REG_MASK);
        wr_clr  = reg_wr && (reg_addr == REG_CLEAR);
        set_all = evt_set | (wr_tx ? GRP_TX : '0);
        clr_vec = wr_clr ? reg_wdata[STAT_W-1:0] : '0;
        masked  = raw_q & mask_q;
    end

    uart_irq_raw_reg #(.W(STAT_W)) u_raw (
        .clk(clk), .rst_n(rst_n), .set_vec(set_all), .clr_vec(clr_vec), .raw(raw_q)
    );

    uart_irq_mask_reg #(.W(STAT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .load(wr_mask),
        .din(reg_wdata[STAT_W-1:0]), .mask(mask_q)
    );

    uart_irq_router #(.W(STAT_W), .N(N_LINES)) u_route (
        .masked(masked), .lines(lines)
    );

    always_comb begin
        irq_combined = lines[0];
        irq_rx       = lines[1];
        irq_tx       = lines[2];
        irq_rt       = lines[3];
        irq_ms       = lines[4];
        irq_err      = lines[5];
    end

    always_comb begin
        case (reg_addr)
            REG_MASK:   reg_rdata = {{PAD_W{1'b0}}, mask_q};
            REG_RAW:    reg_rdata = {{PAD_W{1'b0}}, raw_q};
            REG_MASKED: reg_rdata = {{PAD_W{1'b0}}, masked};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int STAT_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [STAT_W-1:0] evt_set,
    input logic [STAT_W-1:0] raw_q,
    input logic [STAT_W-1:0] mask_q,
    input logic              irq_combined,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic              irq_rt,
    input logic              irq_ms,
    input logic              irq_err
);
    assert_masked_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd3) |-> (reg_rdata[STAT_W-1:0] == (raw_q & mask_q)));

    assert_combined_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_combined == (irq_rx | irq_tx | irq_rt | irq_ms | irq_err));

    assert_clear_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4) |=>
        ((raw_q & $past(reg_wdata[STAT_W-1:0] & ~evt_set)) == '0));

    assert_clear_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd4) |-> (reg_rdata == '0));

    assert_ro_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 3'd2 || reg_addr == 3'd3) && evt_set == '0) |=>
        ($stable(raw_q) && $stable(mask_q)));

    assert_tx_write_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0) |=> raw_q[5]);

    assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |=> (mask_q == $past(reg_wdata[STAT_W-1:0])));

    assert_event_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.DATA_W(DATA_W), .STAT_W(11)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .raw_q(raw_q), .mask_q(mask_q), .irq_combined(irq_combined),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rt(irq_rt), .irq_ms(irq_ms),
    .irq_err(irq_err)
);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [10:0] evt_set = '0;
    logic irq_combined, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

    int checks = 0;
    int errors = 0;
    logic [10:0] m_raw = '0;
    logic [10:0] m_mask = '0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
        .irq_combined(irq_combined), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one clock cycle of stimulus, model updated after the edge
    task automatic cyc(input bit wr, input logic [2:0] a, input logic [15:0] d,
                       input logic [10:0] s);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_set = s;
        @(posedge clk);
        if (wr) begin
            case (a)
                3'd0: m_raw = m_raw | 11'h020;
                3'd1: m_mask = d[10:0];
                3'd4: m_raw = m_raw & ~d[10:0];
                default: ;
            endcase
        end
        m_raw = m_raw | s;
        @(negedge clk);
        reg_wr = 1'b0; evt_set = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.3;
        v = reg_rdata;
    endtask

    task automatic check_all(input string req);
        logic [15:0] v;
        logic [10:0] mk;
        logic [5:0] exp_l, act_l;
        mk = m_raw & m_mask;
        rd(3'd2, v); check(v == {5'd0, m_raw}, req, v, m_raw);
        rd(3'd1, v); check(v == {5'd0, m_mask}, req, v, m_mask);
        rd(3'd3, v); check(v == {5'd0, mk}, {req, " R1"}, v, mk);
        rd(3'd4, v); check(v == 16'd0, "R5", v, 0);
        exp_l = {|mk[10:7], |mk[3:0], mk[6], mk[5], mk[4], |mk};
        act_l = {irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_combined};
        check(act_l == exp_l, {req, " R2 R3 lines"}, act_l, exp_l);
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 reset");

        // R10 / R2: each status bit alone, all lines enabled
        cyc(1'b1, 3'd1, 16'h07FF, '0);
        for (int b = 0; b < 11; b++) begin
            cyc(1'b0, 3'd0, '0, 11'(1) << b);
            check_all("R10 single bit");
            cyc(1'b1, 3'd4, 16'(1) << b, '0);
            check_all("R4 clear bit");
        end

        // R1 / R8: exhaustive mask sweep over two raw patterns
        for (int p = 0; p < 2; p++) begin
            cyc(1'b0, 3'd0, '0, 11'h7FF);
            if (p == 1) cyc(1'b1, 3'd4, 16'h02AA, '0);
            for (int m = 0; m < 2048; m++) begin
                cyc(1'b1, 3'd1, 16'(m), '0);
                check_all("R8 mask sweep");
            end
        end

        // R6: writes to raw and masked ignored
        cyc(1'b1, 3'd1, 16'h07FF, '0);
        cyc(1'b1, 3'd2, 16'hFFFF, '0);
        check_all("R6 raw write");
        cyc(1'b1, 3'd3, 16'h0000, '0);
        check_all("R6 masked write");

        // R7: tx data write
        cyc(1'b1, 3'd4, 16'hFFFF, '0);
        cyc(1'b1, 3'd0, 16'h0041, '0);
        check_all("R7 tx write");
        rd(3'd0, v); check(v == 0, "R7 read", v, 0);
        check(irq_tx == 1'b1, "R7 irq_tx", irq_tx, 1);

        // R10: set and clear of the same bit in one cycle
        cyc(1'b1, 3'd4, 16'hFFFF, '0);
        cyc(1'b1, 3'd4, 16'h0010, 11'h010);
        check_all("R10 set wins");
        check(irq_rx == 1'b1, "R10 irq_rx", irq_rx, 1);

        // R11: unmapped addresses
        for (int a = 5; a < 8; a++) begin
            cyc(1'b1, 3'(a), 16'hFFFF, '0);
            rd(3'(a), v); check(v == 0, "R11 read", v, 0);
            check_all("R11 write ignored");
        end

        // R9: reset again with state present
        cyc(1'b0, 3'd0, '0, 11'h7FF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_raw = '0; m_mask = '0;
        @(negedge clk);
        check_all("R9 re-reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule